// File: doc/BRIEF.md
# MII management read sequencer

This block lets a host fetch 16-bit values from the management registers of an Ethernet PHY. The host writes a 5-bit PHY register address into an address register and then sets the go bit of the command register. The block raises a busy flag, clocks out a complete management read frame on MDC/MDIO, shifts in the 16 data bits returned by the PHY, and splits the value across a low-byte and a high-byte result register. When the result is in place, busy drops. The host then clears the go bit, which leaves the result untouched.

The frame is driven by an eight-state machine. PH_IDLE goes to PH_PRE when a start is accepted. Each later state lasts a fixed number of MDC periods and then hands over on the falling MDC edge that ends its last bit:
- PH_PRE (32 bits) goes to PH_SOF.
- PH_SOF (2 bits) goes to PH_OPC.
- PH_OPC (2 bits) goes to PH_PHY.
- PH_PHY (5 bits) goes to PH_REG.
- PH_REG (5 bits) goes to PH_TA.
- PH_TA (2 bits) goes to PH_DATA.
- PH_DATA (16 bits) goes back to PH_IDLE and writes the result.

MDC is the system clock divided by `MDC_DIV`. The PHY address is the parameter `PHY_ADR`. A scan-request bit is kept in the command register and mirrored in the status register. It starts no frame.

Top module: `mii_rd_seq`

## Requirements
- R1: After reset the status register reads 0x04, meaning not-valid set and busy and scan clear. The command and both result registers read 0x00, MDC is low and MDIO is not driven.
- R2: The host map has these offsets:
  - 0: command. Bit 0 is go and bit 1 is scan. It reads back bits 1:0.
  - 1: PHY register address. It holds bits 4:0; bits 7:5 read as 0.
  - 2: status. Bit 0 is busy, bit 1 is scan and bit 2 is not-valid.
  - 3: result low byte.
  - 4: result high byte.

  Offsets 2, 3 and 4 are read-only, so writes to them change nothing. Offsets 5 to 7 read as 0.
- R3: A command write that moves bit 0 from 0 to 1 while busy is clear starts a read. Busy and not-valid read 1 from the next clock cycle, and the address register value is captured at that point.
- R4: MDC stays low while idle. During a frame each MDC period is `MDC_DIV` clocks, low for the first half and high for the second, and there are exactly 64 rising edges per frame. Output bits change only while MDC falls, and MDIO input is sampled when MDC rises.
- R5: The frame sends bits in this order:
  - 32 ones;
  - the start pattern 0,1;
  - the read opcode 1,0;
  - `PHY_ADR`, MSB first;
  - the captured register address, MSB first.

  After that, MDIO is released for 2 turnaround bits and 16 data bits.
- R6: Busy stays set for exactly 64×`MDC_DIV` clock cycles. It drops on the same edge that loads the result registers, and not-valid clears at that edge.
- R7: The 16 data bits arrive MSB first. The low result register holds bits 7:0 and the high register holds bits 15:8. Reading PHY register 2 of a standard identifier gives 0x83 and 0x00. Reading register 3 gives a high byte whose top six bits are 000101, so the value masked with 0xFC00 is 0x1400.
- R8: Clearing the go bit after busy drops leaves both result registers and the status register unchanged.
- R9: A start is refused while busy, even if the go bit is rewritten 0 then 1 during the frame. Writing 1 to a go bit that already reads 1 starts nothing.
- R10: Rewriting the address register during a frame does not change the register address sent or the result. The new value reads back.
- R11: Status bit 1 follows command bit 1. Setting scan alone starts no frame: busy stays 0 and MDC stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write strobe, one cycle per write |
| host_addr | input | 3 | Register offset for write and read |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr`, combinational |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the block |
| mdio_oe | output | 1 | MDIO output enable; 0 releases the line |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
The checks assume that `MDC_DIV` is even and at least 2, and that reset is not applied in the middle of a frame. They also assume that `mdio_i` is steady around each rising MDC edge. The assertions further rely on host writes going only to the five defined offsets, one per strobe. The bench's PHY model follows these rules:
- It changes `mdio_i` only on falling MDC, half a period before the block samples.
- It decodes the register address from the frame it observed.

The host tasks issue single-cycle writes at falling clock edges, and start a read only once the previous frame has ended.

// File: rtl/mii_rd_pkg.sv
package mii_rd_pkg;

    localparam int HOST_AW    = 3;
    localparam int HOST_DW    = 8;
    localparam int ADR_BITS   = 5;
    localparam int DATA_BITS  = 16;
    localparam int FRAME_BITS = 64;
    localparam int CNT_BITS   = 5;

    localparam logic [HOST_AW-1:0] OFS_CMD  = 3'd0;
    localparam logic [HOST_AW-1:0] OFS_RADR = 3'd1;
    localparam logic [HOST_AW-1:0] OFS_STAT = 3'd2;
    localparam logic [HOST_AW-1:0] OFS_RLO  = 3'd3;
    localparam logic [HOST_AW-1:0] OFS_RHI  = 3'd4;

    localparam int CMD_GO    = 0;
    localparam int CMD_SCAN  = 1;
    localparam int STAT_BUSY = 0;
    localparam int STAT_SCAN = 1;
    localparam int STAT_NVAL = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_SOF,
        PH_OPC,
        PH_PHY,
        PH_REG,
        PH_TA,
        PH_DATA
    } mii_phase_e;

    // index of the final bit of each phase
    function automatic logic [CNT_BITS-1:0] phase_last(input mii_phase_e p);
        case (p)
            PH_PRE:  return CNT_BITS'(31);
            PH_SOF:  return CNT_BITS'(1);
            PH_OPC:  return CNT_BITS'(1);
            PH_PHY:  return CNT_BITS'(ADR_BITS - 1);
            PH_REG:  return CNT_BITS'(ADR_BITS - 1);
            PH_TA:   return CNT_BITS'(1);
            PH_DATA: return CNT_BITS'(DATA_BITS - 1);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/mii_mdc_gen.sv
module mii_mdc_gen #(
    parameter int MDC_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int HALF = MDC_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          edge_due;

    assign edge_due = run && (cnt_q == LAST);
    assign rise     = edge_due && !mdc;
    assign fall     = edge_due &&  mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (edge_due) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/mii_frame_fsm.sv
module mii_frame_fsm
    import mii_rd_pkg::*;
#(
    parameter logic [ADR_BITS-1:0] PHY_ADR = 5'h01
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ADR_BITS-1:0]  reg_adr,
    input  logic                 rise,
    input  logic                 fall,
    input  logic                 mdio_i,
    output logic                 active,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic                 done,
    output logic [DATA_BITS-1:0] rdata
);
    localparam logic [ADR_BITS-1:0] PHY_V = PHY_ADR;

    mii_phase_e           phase_q, phase_d;
    logic [CNT_BITS-1:0]  bit_q;
    logic [ADR_BITS-1:0]  radr_q;
    logic [DATA_BITS-1:0] shift_q;
    logic                 last_bit;
    logic                 step;
    logic [2:0]           fld_idx;

    assign last_bit = (bit_q == phase_last(phase_q));
    assign step     = fall && last_bit;
    assign fld_idx  = 3'(CNT_BITS'(ADR_BITS - 1) - bit_q);

    // next phase
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: if (start) phase_d = PH_PRE;
            PH_PRE:  if (step)  phase_d = PH_SOF;
            PH_SOF:  if (step)  phase_d = PH_OPC;
            PH_OPC:  if (step)  phase_d = PH_PHY;
            PH_PHY:  if (step)  phase_d = PH_REG;
            PH_REG:  if (step)  phase_d = PH_TA;
            PH_TA:   if (step)  phase_d = PH_DATA;
            PH_DATA: if (step)  phase_d = PH_IDLE;
        endcase
    end

    // state register, bit counter, captured address, input shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            bit_q   <= '0;
            radr_q  <= '0;
            shift_q <= '0;
        end else begin
            phase_q <= phase_d;
            if (phase_q == PH_IDLE) begin
                bit_q <= '0;
                if (start) radr_q <= reg_adr;
            end else if (fall) begin
                bit_q <= last_bit ? '0 : bit_q + 1'b1;
            end
            if (rise && phase_q == PH_DATA)
                shift_q <= {shift_q[DATA_BITS-2:0], mdio_i};
        end
    end

    // outputs
    always_comb begin
        mdio_o  = 1'b1;
        mdio_oe = 1'b1;
        unique case (phase_q)
            PH_IDLE: mdio_oe = 1'b0;
            PH_PRE:  mdio_o  = 1'b1;
            PH_SOF:  mdio_o  = bit_q[0];
            PH_OPC:  mdio_o  = ~bit_q[0];
            PH_PHY:  mdio_o  = PHY_V[fld_idx];
            PH_REG:  mdio_o  = radr_q[fld_idx];
            PH_TA:   mdio_oe = 1'b0;
            PH_DATA: mdio_oe = 1'b0;
        endcase
        active = (phase_q != PH_IDLE);
        done   = (phase_q == PH_DATA) && step;
        rdata  = shift_q;
    end

endmodule

// File: rtl/mii_host_regs.sv
module mii_host_regs
    import mii_rd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_wr,
    input  logic [HOST_AW-1:0]   host_addr,
    input  logic [HOST_DW-1:0]   host_wdata,
    output logic [HOST_DW-1:0]   host_rdata,
    input  logic                 done,
    input  logic [DATA_BITS-1:0] rdata,
    output logic                 start,
    output logic [ADR_BITS-1:0]  reg_adr,
    output logic                 busy,
    output logic                 nvalid,
    output logic [HOST_DW-1:0]   res_lo,
    output logic [HOST_DW-1:0]   res_hi
);
    logic [1:0] cmd_q;
    logic       wr_cmd;
    logic       wr_radr;

    assign wr_cmd  = host_wr && (host_addr == OFS_CMD);
    assign wr_radr = host_wr && (host_addr == OFS_RADR);
    assign start   = wr_cmd && host_wdata[CMD_GO] && !cmd_q[CMD_GO] && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            reg_adr <= '0;
            busy    <= 1'b0;
            nvalid  <= 1'b1;
            res_lo  <= '0;
            res_hi  <= '0;
        end else begin
            if (wr_cmd)  cmd_q   <= host_wdata[1:0];
            if (wr_radr) reg_adr <= host_wdata[ADR_BITS-1:0];
            if (start) begin
                busy   <= 1'b1;
                nvalid <= 1'b1;
            end else if (done) begin
                busy   <= 1'b0;
                nvalid <= 1'b0;
                res_lo <= rdata[HOST_DW-1:0];
                res_hi <= rdata[DATA_BITS-1:HOST_DW];
            end
        end
    end

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            OFS_CMD:  host_rdata[1:0] = cmd_q;
            OFS_RADR: host_rdata[ADR_BITS-1:0] = reg_adr;
            OFS_STAT: begin
                host_rdata[STAT_BUSY] = busy;
                host_rdata[STAT_SCAN] = cmd_q[CMD_SCAN];
                host_rdata[STAT_NVAL] = nvalid;
            end
            OFS_RLO:  host_rdata = res_lo;
            OFS_RHI:  host_rdata = res_hi;
            default:  host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mii_rd_seq.sv
module mii_rd_seq
    import mii_rd_pkg::*;
#(
    parameter int                   MDC_DIV = 8,
    parameter logic [ADR_BITS-1:0]  PHY_ADR = 5'h01
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    output logic               mdc,
    output logic               mdio_o,
    output logic               mdio_oe,
    input  logic               mdio_i
);
    logic                 go_pulse;
    logic                 frame_done;
    logic                 frame_run;
    logic                 mdc_rise;
    logic                 mdc_fall;
    logic                 st_busy;
    logic                 st_nvalid;
    logic [ADR_BITS-1:0]  reg_adr;
    logic [DATA_BITS-1:0] frame_data;
    logic [HOST_DW-1:0]   res_lo;
    logic [HOST_DW-1:0]   res_hi;

    mii_host_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .done       (frame_done),
        .rdata      (frame_data),
        .start      (go_pulse),
        .reg_adr    (reg_adr),
        .busy       (st_busy),
        .nvalid     (st_nvalid),
        .res_lo     (res_lo),
        .res_hi     (res_hi)
    );

    mii_mdc_gen #(.MDC_DIV(MDC_DIV)) u_mdc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (frame_run),
        .mdc   (mdc),
        .rise  (mdc_rise),
        .fall  (mdc_fall)
    );

    mii_frame_fsm #(.PHY_ADR(PHY_ADR)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (go_pulse),
        .reg_adr (reg_adr),
        .rise    (mdc_rise),
        .fall    (mdc_fall),
        .mdio_i  (mdio_i),
        .active  (frame_run),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .done    (frame_done),
        .rdata   (frame_data)
    );

endmodule

// File: rtl/mii_rd_seq_chk.sv
module mii_rd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       nvalid,
    input logic       start,
    input logic       done,
    input logic       mdc,
    input logic       mdio_o,
    input logic       mdio_oe,
    input logic [7:0] res_lo,
    input logic [7:0] res_hi
);
    a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && nvalid));

    a_r4_mdc_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    a_r5_first_bit_driven_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mdio_oe && mdio_o));

    a_r5_released_at_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mdio_oe);

    a_r6_busy_implies_nvalid: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> nvalid);

    a_r6_busy_ends_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> ($stable(res_lo) && $stable(res_hi)));

endmodule

bind mii_rd_seq mii_rd_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (st_busy),
    .nvalid  (st_nvalid),
    .start   (go_pulse),
    .done    (frame_done),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .res_lo  (res_lo),
    .res_hi  (res_hi)
);

// File: tb/mii_rd_seq_test.sv
`timescale 1ns/100ps
module mii_rd_seq_test;
    import mii_rd_pkg::*;

    localparam int          DIV  = 8;
    localparam int          HALF = DIV / 2;
    localparam logic [4:0]  PHYA = 5'h11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       mdc, mdio_o, mdio_oe;
    logic       mdio_i = 1'b1;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 0;

    // PHY model state
    int          mcnt = 0;
    logic [63:0] hdr = '0;
    bit          oe_late = 0;
    bit          oe_miss = 0;

    always #2.5 clk = ~clk;

    mii_rd_seq #(.MDC_DIV(DIV), .PHY_ADR(PHYA)) uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    function automatic logic [15:0] phy_val(input logic [4:0] a);
        case (a)
            5'd2:    return 16'h0083;
            5'd3:    return 16'h1405;
            default: return 16'hA5C3 ^ {a, 6'b0, a};
        endcase
    endfunction

    always @(posedge mdc) begin
        if (mcnt < 64) begin
            hdr[mcnt] = mdio_o;
            if (mcnt >= 46 && mdio_oe) oe_late = 1;
            if (mcnt < 46 && !mdio_oe) oe_miss = 1;
        end
        mcnt = mcnt + 1;
    end

    always @(negedge mdc) begin
        logic [15:0] v;
        v = phy_val({hdr[41], hdr[42], hdr[43], hdr[44], hdr[45]});
        if (mcnt >= 48 && mcnt < 64) mdio_i <= v[63 - mcnt];
        else                         mdio_i <= 1'b1;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic wait_idle(output int nbusy, output int nhigh);
        host_addr = OFS_STAT;
        #1;
        nbusy = 0; nhigh = 0;
        while (host_rdata[STAT_BUSY] && nbusy < 20000) begin
            nbusy++;
            if (mdc) nhigh++;
            @(negedge clk); #1;
        end
    endtask

    task automatic arm_model();
        mcnt = 0; hdr = '0; oe_late = 0; oe_miss = 0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(OFS_STAT, d); chk("R1", "status after reset", d, 8'h04);
        rd(OFS_CMD, d);  chk("R1", "command after reset", d, 8'h00);
        rd(OFS_RLO, d);  chk("R1", "low result after reset", d, 8'h00);
        rd(OFS_RHI, d);  chk("R1", "high result after reset", d, 8'h00);
        chk("R1", "mdc and oe after reset", {mdc, mdio_oe}, 2'b00);
    endtask

    task automatic t_regmap();
        logic [7:0] d;
        wr(OFS_RADR, 8'hFF); rd(OFS_RADR, d); chk("R2", "address readback", d, 8'h1F);
        wr(OFS_STAT, 8'hFF); rd(OFS_STAT, d); chk("R2", "status write ignored", d, 8'h04);
        wr(OFS_RLO, 8'hAA);  rd(OFS_RLO, d);  chk("R2", "low write ignored", d, 8'h00);
        wr(OFS_RHI, 8'h55);  rd(OFS_RHI, d);  chk("R2", "high write ignored", d, 8'h00);
        rd(3'd5, d); chk("R2", "offset 5", d, 8'h00);
        rd(3'd7, d); chk("R2", "offset 7", d, 8'h00);
        wr(OFS_CMD, 8'hFC); rd(OFS_CMD, d); chk("R2", "command readback", d, 8'h00);
        rd(OFS_STAT, d); chk("R2", "no start from cleared go", d, 8'h04);
    endtask

    task automatic t_read(input logic [4:0] a);
        logic [7:0] d;
        logic [15:0] e;
        int nb, nh;
        e = phy_val(a);
        arm_model();
        wr(OFS_RADR, {3'b0, a});
        wr(OFS_CMD, 8'h00);
        wr(OFS_CMD, 8'h01);
        rd(OFS_STAT, d); chk("R3", "status right after start", d, 8'h05);
        wait_idle(nb, nh);
        chk("R6", "busy cycles", nb, 64 * DIV);
        chk("R4", "mdc high cycles", nh, 64 * HALF);
        chk("R4", "mdc rising edges", mcnt, 64);
        chk("R5", "preamble", hdr[31:0], 32'hFFFF_FFFF);
        chk("R5", "start and opcode", {hdr[32], hdr[33], hdr[34], hdr[35]}, 4'b0110);
        chk("R5", "phy address", {hdr[36], hdr[37], hdr[38], hdr[39], hdr[40]}, PHYA);
        chk("R5", "register address", {hdr[41], hdr[42], hdr[43], hdr[44], hdr[45]}, a);
        chk("R5", "drive then release", {oe_miss, oe_late}, 2'b00);
        rd(OFS_RLO, d); chk("R7", "low result", d, e[7:0]);
        rd(OFS_RHI, d); chk("R7", "high result", d, e[15:8]);
        rd(OFS_STAT, d); chk("R6", "status after done", d, 8'h00);
    endtask

    task automatic t_identity();
        logic [7:0] d;
        t_read(5'd2);
        rd(OFS_RLO, d); chk("R7", "id2 low", d, 8'h83);
        rd(OFS_RHI, d); chk("R7", "id2 high", d, 8'h00);
        t_read(5'd3);
        rd(OFS_RHI, d); chk("R7", "id3 masked", {d & 8'hFC, 8'h00}, 16'h1400);
    endtask

    task automatic t_clear_keeps();
        logic [7:0] d;
        logic [15:0] e;
        e = phy_val(5'h15);
        t_read(5'h15);
        wr(OFS_CMD, 8'h00);
        rd(OFS_RLO, d);  chk("R8", "low kept after clear", d, e[7:0]);
        rd(OFS_RHI, d);  chk("R8", "high kept after clear", d, e[15:8]);
        rd(OFS_STAT, d); chk("R8", "status kept after clear", d, 8'h00);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] d;
        logic [15:0] e;
        int nb, nh;
        e = phy_val(5'd7);
        wr(OFS_RADR, 8'h07);
        wr(OFS_CMD, 8'h00);
        arm_model();
        wr(OFS_CMD, 8'h01);
        repeat (20) @(negedge clk);
        wr(OFS_CMD, 8'h00);
        wr(OFS_CMD, 8'h01);
        wait_idle(nb, nh);
        repeat (3 * DIV) @(negedge clk);
        chk("R9", "single frame despite rewrite", mcnt, 64);
        rd(OFS_STAT, d); chk("R9", "idle after refused start", d, 8'h00);
        rd(OFS_RLO, d);  chk("R9", "result of first read", d, e[7:0]);
        wr(OFS_CMD, 8'h01);
        repeat (3 * DIV) @(negedge clk);
        chk("R9", "go already set starts nothing", mcnt, 64);
        rd(OFS_STAT, d); chk("R9", "status stays idle", d, 8'h00);
    endtask

    task automatic t_addr_change();
        logic [7:0] d;
        int nb, nh;
        wr(OFS_RADR, 8'h02);
        wr(OFS_CMD, 8'h00);
        arm_model();
        wr(OFS_CMD, 8'h01);
        repeat (10) @(negedge clk);
        wr(OFS_RADR, 8'h03);
        wait_idle(nb, nh);
        chk("R10", "address sent", {hdr[41], hdr[42], hdr[43], hdr[44], hdr[45]}, 5'd2);
        rd(OFS_RLO, d);  chk("R10", "low from captured address", d, 8'h83);
        rd(OFS_RHI, d);  chk("R10", "high from captured address", d, 8'h00);
        rd(OFS_RADR, d); chk("R10", "new address readback", d, 8'h03);
    endtask

    task automatic t_scan();
        logic [7:0] d;
        wr(OFS_CMD, 8'h00);
        arm_model();
        wr(OFS_CMD, 8'h02);
        rd(OFS_STAT, d); chk("R11", "scan mirrored", d, 8'h02);
        repeat (4 * DIV) @(negedge clk);
        chk("R11", "no frame for scan", {mcnt[7:0], 7'b0, mdc}, 16'h0000);
        wr(OFS_CMD, 8'h00);
        rd(OFS_STAT, d); chk("R11", "scan cleared", d, 8'h00);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_identity();
        t_read(5'h00);
        t_read(5'h1F);
        t_clear_keeps();
        t_busy_ignore();
        t_addr_change();
        t_scan();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule